// File: doc/BRIEF.md
# PCM Port Clock-Edge and Delay Adjuster

This block sits between a serial PCM line and the time-slot logic inside the chip. It runs on the fast system clock. It observes the PCM data clock through a synchronizer and turns each data-clock transition into a one-cycle rising or falling strobe. The receive path captures the serial input on whichever edge is programmed for it. The transmit path launches outgoing bits on its own programmed edge.

Each path can be lengthened by whole data-clock periods. One shift control adds a period to both receive and transmit. A second control adds a period to transmit only. When both are set, transmit is two periods late. Every delay stage advances only on its own path's edge strobe, so a delay equals exactly one data-clock period whichever edge is chosen.

An 8-bit control register holds all the controls and is reached through a small address/data bus. Register contents move into an active copy at the next data-clock strobe. Two 2-bit offset fields are only stored and driven out for a downstream frame-alignment unit. The edge tracker is a state machine with three states:
- `EDGE_INIT` waits until the synchronizer has filled and then moves to `EDGE_LOW` or `EDGE_HIGH` without emitting a strobe.
- `EDGE_LOW` moves to `EDGE_HIGH` when it sees a high level, and emits the rise strobe.
- `EDGE_HIGH` moves to `EDGE_LOW` when it sees a low level, and emits the fall strobe.

The system clock must run at least four times faster than the data clock.

Top module: `pcm_edge_adjust`

## Requirements
- R1: After reset, the register reads 0x00. `rx_data`, `pcm_tx`, `dn_offset` and `up_offset` are all zero.
- R2: A write to the register address stores `bus_wdata` in the next cycle and reads back unchanged. The bit layout, bit 7 down to bit 0, is: shift-both, receive offset[1:0], receive-rising, shift-transmit, transmit offset[1:0], transmit-rising.
- R3: `dn_offset` shows bits 6:5 and `up_offset` shows bits 2:1 of the active control. These fields have no effect on either data path.
- R4: With receive-rising (bit 4) at 1, `pcm_rx` is captured on the rising data-clock edge. With it at 0, capture happens on the falling edge.
- R5: With transmit-rising (bit 0) at 1, `pcm_tx` changes after the rising data-clock edge. With it at 0, it changes after the falling edge.
- R6: With shift-both (bit 7) set, `rx_data` lags the captured input by one extra data-clock period. With it clear, there is no extra lag. Shift-transmit (bit 3) never delays receive.
- R7: Transmit lags by one extra data-clock period for each of bit 7 and bit 3 that is set, so two periods when both are set.
- R8: A write to any other address leaves the register unchanged. A read of any other address returns 0x00.
- R9: `rx_data` and `pcm_tx` change only in response to a data-clock edge. While the data clock is still, they hold even when the serial inputs toggle. Rise and fall strobes never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| pcm_clk | input | 1 | PCM data clock (asynchronous) |
| pcm_rx | input | 1 | Serial PCM receive input |
| rx_data | output | 1 | Received bit toward time-slot logic |
| tx_data | input | 1 | Transmit bit from time-slot logic |
| pcm_tx | output | 1 | Serial PCM transmit output |
| dn_offset | output | 2 | Active receive offset field |
| up_offset | output | 2 | Active transmit offset field |

## Verification
Some properties are checked by the assertions on every cycle:
- A register write lands exactly one cycle later.
- Writes to foreign addresses leave the register untouched.
- The rise and fall strobes are mutually exclusive.
- Both serial outputs hold in any cycle that had no strobe.

The bench scenarios cover what needs a reference model counting data-clock periods. For all sixteen combinations of the four timing bits, they check which edge captures or launches a bit and how many periods of lag each path adds. They also confirm that the offset fields leave the data untouched.

// File: rtl/pcm_adj_pkg.sv
package pcm_adj_pkg;

    typedef struct packed {
        logic       shift_both;
        logic [1:0] dn_off;
        logic       dn_rise;
        logic       shift_tx;
        logic [1:0] up_off;
        logic       up_rise;
    } pcm_ctrl_t;

    localparam int CTRL_W = $bits(pcm_ctrl_t);

    typedef enum logic [1:0] {
        EDGE_INIT = 2'd0,
        EDGE_LOW  = 2'd1,
        EDGE_HIGH = 2'd2
    } edge_state_t;

endpackage

// File: rtl/pcm_clk_edge.sv
module pcm_clk_edge
    import pcm_adj_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pcm_clk,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    logic [CNT_W-1:0]       settle_cnt;
    logic                   settled;
    edge_state_t            state, state_nxt;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= pcm_clk;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign lvl     = sync_q[SYNC_STAGES-1];
    assign settled = (settle_cnt == CNT_W'(SYNC_STAGES));

    // settle counter: the synchronizer holds reset values until it has filled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              settle_cnt <= '0;
        else if (state == EDGE_INIT && !settled) settle_cnt <= settle_cnt + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EDGE_INIT;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            EDGE_INIT: if (settled) state_nxt = lvl ? EDGE_HIGH : EDGE_LOW;
            EDGE_LOW:  if (lvl)     state_nxt = EDGE_HIGH;
            EDGE_HIGH: if (!lvl)    state_nxt = EDGE_LOW;
            default:                state_nxt = EDGE_INIT;
        endcase
    end

    // outputs
    always_comb begin
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        unique case (state)
            EDGE_INIT: ;
            EDGE_LOW:  rise_stb = lvl;
            EDGE_HIGH: fall_stb = !lvl;
            default:   ;
        endcase
    end

endmodule

// File: rtl/pcm_ctrl_regs.sv
module pcm_ctrl_regs
    import pcm_adj_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [CTRL_W-1:0] bus_rdata,
    input  logic              upd_stb,
    output pcm_ctrl_t         ctrl_q,
    output pcm_ctrl_t         ctrl_act
);
    logic hit;

    assign hit = (bus_addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            ctrl_q <= '0;
        else if (bus_wr && hit) ctrl_q <= pcm_ctrl_t'(bus_wdata);
    end

    // active copy moves only on a data-clock strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_act <= '0;
        else if (upd_stb) ctrl_act <= ctrl_q;
    end

    assign bus_rdata = hit ? CTRL_W'(ctrl_q) : '0;

endmodule

// File: rtl/pcm_delay_line.sv
module pcm_delay_line #(
    parameter int MAX_DLY = 2,
    localparam int SEL_W  = $clog2(MAX_DLY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);
    logic [MAX_DLY:0] stage;

    for (genvar i = 0; i <= MAX_DLY; i++) begin : g_stage
        if (i == 0) begin : g_cap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   stage[0] <= 1'b0;
                else if (adv) stage[0] <= din;
            end
        end else begin : g_shift
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   stage[i] <= 1'b0;
                else if (adv) stage[i] <= stage[i-1];
            end
        end
    end

    always_comb begin
        dout = stage[MAX_DLY];
        for (int i = MAX_DLY; i >= 0; i--) begin
            if (sel == SEL_W'(i)) dout = stage[i];
        end
    end

endmodule

// File: rtl/pcm_edge_adjust.sv
module pcm_edge_adjust
    import pcm_adj_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 6'h14,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              pcm_clk,
    input  logic              pcm_rx,
    output logic              rx_data,
    input  logic              tx_data,
    output logic              pcm_tx,
    output logic [1:0]        dn_offset,
    output logic [1:0]        up_offset
);
    localparam int RX_MAX = 1;
    localparam int TX_MAX = 2;
    localparam int TX_SW  = $clog2(TX_MAX + 1);

    logic       rise_stb, fall_stb;
    logic       rx_adv, tx_adv;
    logic [TX_SW-1:0] tx_sel;
    pcm_ctrl_t  ctrl_q, ctrl_act;

    pcm_clk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pcm_clk  (pcm_clk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    pcm_ctrl_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .upd_stb   (rise_stb | fall_stb),
        .ctrl_q    (ctrl_q),
        .ctrl_act  (ctrl_act)
    );

    assign rx_adv = ctrl_act.dn_rise ? rise_stb : fall_stb;
    assign tx_adv = ctrl_act.up_rise ? rise_stb : fall_stb;
    assign tx_sel = TX_SW'(ctrl_act.shift_both) + TX_SW'(ctrl_act.shift_tx);

    pcm_delay_line #(.MAX_DLY(RX_MAX)) u_rx_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (rx_adv),
        .din   (pcm_rx),
        .sel   (ctrl_act.shift_both),
        .dout  (rx_data)
    );

    pcm_delay_line #(.MAX_DLY(TX_MAX)) u_tx_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tx_adv),
        .din   (tx_data),
        .sel   (tx_sel),
        .dout  (pcm_tx)
    );

    assign dn_offset = ctrl_act.dn_off;
    assign up_offset = ctrl_act.up_off;

endmodule

// File: rtl/pcm_edge_adjust_chk.sv
module pcm_edge_adjust_chk
    import pcm_adj_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input pcm_ctrl_t         ctrl_q,
    input logic              rise_stb,
    input logic              fall_stb,
    input logic              rx_data,
    input logic              pcm_tx
);
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_ADDR) |=> (ctrl_q == pcm_ctrl_t'($past(bus_wdata))));

    assert_foreign_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != REG_ADDR) |=> $stable(ctrl_q));

    assert_single_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb || fall_stb) |=> $stable(rx_data));

    assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb || fall_stb) |=> $stable(pcm_tx));

endmodule

bind pcm_edge_adjust pcm_edge_adjust_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .rx_data   (rx_data),
    .pcm_tx    (pcm_tx)
);

// File: tb/sim_pcm_edge_adjust.sv
module sim_pcm_edge_adjust;
    localparam int         CLK_PERIOD = 10;
    localparam int         PER        = 16;
    localparam int         AW         = 6;
    localparam logic [5:0] RADDR      = 6'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          pcm_clk = 1'b0;
    logic          pcm_rx = 1'b0;
    logic          rx_data;
    logic          tx_data = 1'b0;
    logic          pcm_tx;
    logic [1:0]    dn_offset, up_offset;

    int   checks = 0;
    int   fails  = 0;
    int   m      = 0;
    bit   done   = 0;
    logic d_hist [0:1023];
    logic e_hist [0:1023];
    logic [15:0] lfsr = 16'hACE1;

    pcm_edge_adjust #(.ADDR_W(AW), .REG_ADDR(RADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pcm_clk(pcm_clk),
        .pcm_rx(pcm_rx), .rx_data(rx_data), .tx_data(tx_data), .pcm_tx(pcm_tx),
        .dn_offset(dn_offset), .up_offset(up_offset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // one data-clock period: high for p 0..7, low for p 8..15, new bits at p 12
    task automatic run_period(bit do_chk, bit drs, bit dne, bit osh, bit upe);
        int dr, dt;
        dr = drs ? 1 : 0;
        dt = (drs ? 1 : 0) + (osh ? 1 : 0);
        for (int p = 0; p < PER; p++) begin
            @(negedge clk);
            if (do_chk && p == 6) begin
                // only the rising-edge choice has moved yet in this period
                chk(dne ? "R4" : "R4", "rx after rise",
                    int'(rx_data), int'(dne ? d_hist[m-1-dr] : d_hist[m-2-dr]));
                chk(upe ? "R5" : "R5", "tx after rise",
                    int'(pcm_tx), int'(upe ? e_hist[m-1-dt] : e_hist[m-2-dt]));
            end
            if (do_chk && p == 14) begin
                chk(drs ? "R6" : "R4", "rx lag", int'(rx_data), int'(d_hist[m-1-dr]));
                chk((drs || osh) ? "R7" : "R5", "tx lag", int'(pcm_tx), int'(e_hist[m-1-dt]));
            end
            pcm_clk = (p < 8);
            if (p == 12) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                pcm_rx  = lfsr[0];
                tx_data = lfsr[7];
                d_hist[m] = lfsr[0];
                e_hist[m] = lfsr[7];
            end
        end
        m++;
    endtask

    task automatic t_reset_state_r1();
        logic [7:0] v;
        bus_read(RADDR, v);
        chk("R1", "reg after reset", int'(v), 0);
        chk("R1", "rx_data after reset", int'(rx_data), 0);
        chk("R1", "pcm_tx after reset", int'(pcm_tx), 0);
        chk("R1", "offsets after reset", int'({dn_offset, up_offset}), 0);
    endtask

    task automatic t_register_access_r2_r8();
        logic [7:0] v;
        bus_write(RADDR, 8'hA5);
        bus_read(RADDR, v);
        chk("R2", "readback A5", int'(v), 8'hA5);
        bus_write(RADDR ^ 6'h01, 8'hFF);
        bus_read(RADDR, v);
        chk("R8", "reg after foreign write", int'(v), 8'hA5);
        bus_read(RADDR + 6'h01, v);
        chk("R8", "foreign read", int'(v), 0);
        bus_write(RADDR, 8'h5A);
        bus_read(RADDR, v);
        chk("R2", "readback 5A", int'(v), 8'h5A);
    endtask

    task automatic t_timing_combo(int c);
        bit drs, dne, osh, upe;
        logic [1:0] od, ou;
        drs = c[3]; dne = c[2]; osh = c[1]; upe = c[0];
        od = 2'(c + 1); ou = 2'(~c);
        bus_write(RADDR, {drs, od, dne, osh, ou, upe});
        for (int k = 0; k < 3; k++) run_period(1'b0, drs, dne, osh, upe);
        for (int k = 0; k < 6; k++) run_period(1'b1, drs, dne, osh, upe);
        chk("R3", "dn_offset", int'(dn_offset), int'(od));
        chk("R3", "up_offset", int'(up_offset), int'(ou));
    endtask

    task automatic t_still_clock_r9();
        logic rx0, tx0;
        rx0 = rx_data; tx0 = pcm_tx;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            pcm_rx = ~pcm_rx; tx_data = ~tx_data;
            if (k % 8 == 7) begin
                chk("R9", "rx held", int'(rx_data), int'(rx0));
                chk("R9", "tx held", int'(pcm_tx), int'(tx0));
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset_state_r1();
        t_register_access_r2_r8();
        for (int k = 0; k < 2; k++) run_period(1'b0, 0, 0, 0, 0);
        for (int c = 0; c < 16; c++) t_timing_combo(c);
        t_still_clock_r9();
        finish_run();
    end

endmodule